// File: doc/BRIEF.md
# Dynamic Mesh Packet Router

This block is the packet switch that sits in every tile of a two-dimensional mesh. It has five ports: the local processor and the north, south, east and west neighbours. Traffic is fire-and-forget. A packet is one header word followed by a number of payload words. The destination tile and the payload count are read from the header only, and the network never generates an acknowledgement or a reply. Switching is wormhole: a header claims an output, and that output then carries the rest of the packet from the same input before any other packet can use it.

Each input has a small FIFO. The upstream sender tracks that FIFO with credits, and the router returns one credit for every word it removes. Each output keeps a credit count for the buffer of the neighbour it feeds, and it sends a word only while that count is non-zero. The pipeline has two stages. In the first stage the router decodes the route, arbitrates and reads the winning FIFO head. In the second stage the word crosses the crossbar into the output register. Routing is dimension-ordered, X first and then Y. The tile's own coordinates are parameters. The block holds no state outside its own instance, so two identical copies can form two independent networks.

Top module: `mesh_router`

## Requirements
- R1: When the header's destination X (bits 4:0) is greater than the tile's X, the packet leaves on the east port (index 3). When it is less, the packet leaves on the west port (index 4). This holds whatever the destination Y is.
- R2: When destination X equals the tile's X, a destination Y (bits 9:5) greater than the tile's Y routes to north (index 1), and a smaller one routes to south (index 2).
- R3: When both coordinates equal the tile's own, the packet is ejected on the local port (index 0).
- R4: After a header wins an output, that output carries exactly the header plus the payload count (bits 14:10) of words from the same input, in order and with no words from any other input between them.
- R5: The output is released in the cycle its last word is sent. A header with a payload count of zero forms a complete one-word packet.
- R6: Each output grants competing headers in round-robin order: the search starts at the input after the last winner. Payload words never take part in arbitration.
- R7: Each output starts with a credit count equal to the input FIFO depth (4), spends one credit per word sent and gains one per out_credit_i pulse. It sends nothing while the count is zero.
- R8: in_credit_o pulses once for every word removed from that input's FIFO, in the cycle after the removal.
- R9: On an idle router with credits available, a word presented at an input appears on its output two clock edges later.
- R10: Words pass through unchanged, including header bits 31:15.
- R11: While reset is active, every output valid, output data and credit-return signal is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 5 | Word present on each input port |
| in_data_i | input | 5x32 | Input word per port |
| in_credit_o | output | 5 | One-cycle credit return per dequeued input word |
| out_valid_o | output | 5 | Word present on each output port |
| out_data_o | output | 5x32 | Output word per port |
| out_credit_i | input | 5 | Credit returned by the downstream buffer of each output |

## Verification
The embedded assertions check on every cycle that the FIFOs never overflow or underflow, that the output credit counts stay within the buffer depth and that no word leaves without a credit. They also check that an input is bound to at most one output, that a locked output keeps its owner until its last word has gone, and that every release coincides with a word being sent. The bench scenarios cover the behaviour that spans many cycles or depends on traffic: the route chosen for each coordinate relation, round-robin grant order under contention, the two-cycle latency, holding at exactly four words when a neighbour stalls, and word-exact contiguous delivery of random traffic with random back-pressure.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  localparam int NP = 5;
  localparam int PW = $clog2(NP);

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_SOUTH = 3'd2,
    P_EAST  = 3'd3,
    P_WEST  = 3'd4
  } port_e;
endpackage

// File: rtl/rtr_in_fifo.sv
module rtr_in_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              nempty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign head_o   = mem_q[rd_q];
  assign nempty_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_i) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CW'(DEPTH)));

  // R8
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/rtr_route.sv
module rtr_route
  import rtr_pkg::*;
#(
  parameter int COORD_W = 5,
  parameter int X_ID    = 0,
  parameter int Y_ID    = 0
) (
  input  logic [2*COORD_W-1:0] dest_i,
  output port_e                dir_o
);
  logic [COORD_W-1:0] dx, dy;
  assign dx = dest_i[COORD_W-1:0];
  assign dy = dest_i[2*COORD_W-1:COORD_W];

  // X resolved before Y
  always_comb begin
    if (dx > COORD_W'(X_ID))      dir_o = P_EAST;
    else if (dx < COORD_W'(X_ID)) dir_o = P_WEST;
    else if (dy > COORD_W'(Y_ID)) dir_o = P_NORTH;
    else if (dy < COORD_W'(Y_ID)) dir_o = P_SOUTH;
    else                          dir_o = P_LOCAL;
  end
endmodule

// File: rtl/rtr_out_port.sv
module rtr_out_port #(
  parameter int NP       = 5,
  parameter int PW       = 3,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 5,
  parameter int CRED_MAX = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             req_i,
  input  logic [NP-1:0]             nempty_i,
  input  logic [NP-1:0][DATA_W-1:0] head_i,
  input  logic [NP-1:0][LEN_W-1:0]  len_i,
  input  logic                      credit_i,
  output logic [NP-1:0]             pop_o,
  output logic                      locked_o,
  output logic [PW-1:0]             owner_o,
  output logic                      out_valid_o,
  output logic [DATA_W-1:0]         out_data_o
);
  localparam int CW    = $clog2(CRED_MAX + 2);
  localparam int CNT_W = LEN_W + 1;

  logic              locked_q;
  logic [PW-1:0]     owner_q, rr_q, win, cur;
  logic [CNT_W-1:0]  cnt_q, words, words_left;
  logic [CW-1:0]     cred_q, cred_n;
  logic              grant_ok, xfer;

  // stage 1: round-robin pick, path select, FIFO read
  always_comb begin
    int idx;
    grant_ok = 1'b0;
    win      = '0;
    for (int k = 1; k <= NP; k++) begin
      idx = (int'(rr_q) + k) % NP;
      if (!grant_ok && req_i[idx]) begin
        grant_ok = 1'b1;
        win      = PW'(idx);
      end
    end
    cur        = locked_q ? owner_q : win;
    xfer       = (locked_q || grant_ok) && nempty_i[cur] && (cred_q != '0);
    pop_o      = '0;
    if (xfer) pop_o[cur] = 1'b1;
    words      = locked_q ? cnt_q : (CNT_W'(len_i[win]) + CNT_W'(1));
    words_left = words - CNT_W'(xfer);
    cred_n     = cred_q - CW'(xfer) + CW'(credit_i);
  end

  // stage 2: traversal into output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q    <= 1'b0;
      owner_q     <= '0;
      cnt_q       <= '0;
      rr_q        <= PW'(NP - 1);
      cred_q      <= CW'(CRED_MAX);
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      cred_q      <= cred_n;
      out_valid_o <= xfer;
      if (xfer) out_data_o <= head_i[cur];
      if (locked_q || grant_ok) begin
        locked_q <= (words_left != '0);
        owner_q  <= cur;
        cnt_q    <= words_left;
      end
      if (!locked_q && grant_ok) rr_q <= win;
    end
  end

  assign locked_o = locked_q;
  assign owner_o  = owner_q;

  // R7
  cred_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cred_q <= CW'(CRED_MAX));

  // R7
  send_needs_cred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(cred_q) != '0));

  // R4
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && cnt_q > CNT_W'(1)) |=> (locked_q && $stable(owner_q)));

  // R5
  release_on_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> out_valid_o);
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import rtr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 5,
  parameter int LEN_W      = 5,
  parameter int FIFO_DEPTH = 4,
  parameter int X_ID       = 2,
  parameter int Y_ID       = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             in_valid_i,
  input  logic [NP-1:0][DATA_W-1:0] in_data_i,
  output logic [NP-1:0]             in_credit_o,
  output logic [NP-1:0]             out_valid_o,
  output logic [NP-1:0][DATA_W-1:0] out_data_o,
  input  logic [NP-1:0]             out_credit_i
);
  localparam int LEN_LSB = 2 * COORD_W;

  logic [NP-1:0][DATA_W-1:0] head;
  logic [NP-1:0]             nempty, pop, busy;
  logic [NP-1:0][LEN_W-1:0]  plen;
  port_e                     dir [NP];
  logic [NP-1:0][NP-1:0]     req;    // [out][in]
  logic [NP-1:0][NP-1:0]     opop;   // [out][in]
  logic [NP-1:0][NP-1:0]     bound;  // [in][out]
  logic [NP-1:0]             locked;
  logic [NP-1:0][PW-1:0]     owner;

  for (genvar i = 0; i < NP; i++) begin : g_in
    rtr_in_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (in_valid_i[i]),
      .data_i   (in_data_i[i]),
      .pop_i    (pop[i]),
      .head_o   (head[i]),
      .nempty_o (nempty[i])
    );

    rtr_route #(.COORD_W(COORD_W), .X_ID(X_ID), .Y_ID(Y_ID)) u_route (
      .dest_i (head[i][LEN_LSB-1:0]),
      .dir_o  (dir[i])
    );

    assign plen[i] = head[i][LEN_LSB +: LEN_W];
  end

  // an input bound to an output has a payload word at its head, never a header
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      pop[i] = 1'b0;
      for (int o = 0; o < NP; o++) begin
        bound[i][o] = locked[o] && (owner[o] == PW'(i));
        pop[i]      = pop[i] | opop[o][i];
      end
      busy[i] = |bound[i];
    end
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = nempty[i] && !busy[i] && (dir[i] == port_e'(o));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    rtr_out_port #(
      .NP(NP), .PW(PW), .DATA_W(DATA_W), .LEN_W(LEN_W), .CRED_MAX(FIFO_DEPTH)
    ) u_out (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req[o]),
      .nempty_i    (nempty),
      .head_i      (head),
      .len_i       (plen),
      .credit_i    (out_credit_i[o]),
      .pop_o       (opop[o]),
      .locked_o    (locked[o]),
      .owner_o     (owner[o]),
      .out_valid_o (out_valid_o[o]),
      .out_data_o  (out_data_o[o])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_credit_o <= '0;
    else         in_credit_o <= pop;
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R4
    one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(bound[i]));
  end
endmodule

// File: tb/mesh_router_test.sv
module mesh_router_test;
  localparam int NP  = 5;
  localparam int DW  = 32;
  localparam int DEP = 4;
  localparam int XI  = 2;
  localparam int YI  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NP-1:0]         in_valid = '0;
  logic [NP-1:0][DW-1:0] in_data  = '0;
  logic [NP-1:0]         in_credit;
  logic [NP-1:0]         out_valid;
  logic [NP-1:0][DW-1:0] out_data;
  logic [NP-1:0]         out_credit = '0;

  mesh_router #(.X_ID(XI), .Y_ID(YI), .FIFO_DEPTH(DEP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_credit_o(in_credit),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_credit_i(out_credit)
  );

  typedef logic [31:0] wq_t[$];
  typedef int iq_t[$];
  wq_t txq [NP];
  wq_t expq [NP][NP];
  iq_t hlog [NP];
  int tx_cred [NP], sink_out [NP], rem [NP], cur_src [NP], rx_words [NP], rx_pkts [NP];
  logic [NP-1:0] stall = '0, stall_force = '0;
  bit rnd = 0, done = 0;
  int vecs = 0, errs = 0, cyc = 0, lat_sent = 0;
  logic [31:0] lat_word = 32'hFFFF_FFFF;

  function automatic int route(int dx, int dy);
    if (dx > XI) return 3;
    if (dx < XI) return 4;
    if (dy > YI) return 1;
    if (dy < YI) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] mk_hdr(int src, int tag, int dx, int dy, int len);
    return {4'(src), 13'(tag), 5'(len), 5'(dy), 5'(dx)};
  endfunction

  task automatic chk(string r, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic send_pkt(int src, int dx, int dy, int len, int tag);
    int o;
    logic [31:0] w;
    o = route(dx, dy);
    w = mk_hdr(src, tag, dx, dy, len);
    txq[src].push_back(w);
    expq[o][src].push_back(w);
    for (int k = 0; k < len; k++) begin
      w = {4'(src), 28'(tag * 64 + k)};
      txq[src].push_back(w);
      expq[o][src].push_back(w);
    end
  endtask

  task automatic sink_word(int o, logic [31:0] w);
    int s;
    logic [31:0] e;
    rx_words[o]++;
    sink_out[o]++;
    chk("R7 outstanding words within credit window", int'(sink_out[o] <= DEP), 1);
    if (rem[o] == 0) begin
      s = int'(w[31:28]);
      rem[o] = int'(w[14:10]);
      cur_src[o] = s;
      rx_pkts[o]++;
      hlog[o].push_back(s);
      if (w == lat_word) chk("R9 input-to-output latency", cyc - lat_sent, 2);
    end else begin
      rem[o]--;
      s = cur_src[o];
    end
    vecs++;
    if (s >= NP || expq[o][s].size() == 0) begin
      errs++;
      $display("FAIL R4 unexpected word on port %0d: actual %h expected none", o, w);
    end else begin
      e = expq[o][s].pop_front();
      if (w !== e) begin
        errs++;
        $display("FAIL R10 word on port %0d: actual %h expected %h", o, w, e);
      end
    end
  endtask

  // bench-side sources, sinks and reference bookkeeping
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
    if (rst_n) begin
      for (int o = 0; o < NP; o++)
        stall[o] = rnd ? (($urandom % 3) == 0) : stall_force[o];
      for (int p = 0; p < NP; p++)
        if (in_credit[p]) tx_cred[p]++;
      for (int p = 0; p < NP; p++) begin
        in_valid[p] = 1'b0;
        if (txq[p].size() > 0 && tx_cred[p] > 0) begin
          in_data[p]  = txq[p].pop_front();
          in_valid[p] = 1'b1;
          tx_cred[p]--;
          if (in_data[p] == lat_word) lat_sent = cyc;
        end
      end
      for (int o = 0; o < NP; o++) begin
        out_credit[o] = 1'b0;
        if (out_valid[o]) sink_word(o, out_data[o]);
        if (!stall[o] && sink_out[o] > 0) begin
          out_credit[o] = 1'b1;
          sink_out[o]--;
        end
      end
    end
  end

  function automatic bit idle();
    for (int p = 0; p < NP; p++) begin
      if (txq[p].size() != 0 || rem[p] != 0 || sink_out[p] != 0) return 0;
      for (int s = 0; s < NP; s++) if (expq[p][s].size() != 0) return 0;
    end
    return 1;
  endfunction

  task automatic drain();
    do @(posedge clk); while (!idle());
    repeat (6) @(posedge clk);
  endtask

  initial begin
    int base, base2;
    for (int p = 0; p < NP; p++) begin
      tx_cred[p] = DEP; sink_out[p] = 0; rem[p] = 0; cur_src[p] = 0;
      rx_words[p] = 0; rx_pkts[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    // R11
    chk("R11 out_valid in reset", int'(out_valid), 0);
    chk("R11 in_credit in reset", int'(in_credit), 0);
    chk("R11 out_data in reset", int'(out_data != '0), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk);

    // R3 and R9: local ejection on an idle router
    base = rx_pkts[0];
    lat_word = mk_hdr(3, 1, XI, YI, 2);
    send_pkt(3, XI, YI, 2, 1);
    drain();
    chk("R3 local ejection", rx_pkts[0], base + 1);

    // R1: X first
    base = rx_pkts[3];
    send_pkt(0, 5, 0, 1, 2);
    send_pkt(0, 4, 4, 0, 3);
    drain();
    chk("R1 east on larger X regardless of Y", rx_pkts[3], base + 2);
    base = rx_pkts[4];
    send_pkt(0, 0, 4, 3, 4);
    drain();
    chk("R1 west on smaller X", rx_pkts[4], base + 1);

    // R2: Y after X matches
    base = rx_pkts[1];
    send_pkt(0, XI, 4, 2, 5);
    drain();
    chk("R2 north on larger Y", rx_pkts[1], base + 1);
    base = rx_pkts[2];
    send_pkt(0, XI, 0, 1, 6);
    drain();
    chk("R2 south on smaller Y", rx_pkts[2], base + 1);

    // R5: header-only packets from two inputs into one output
    base = rx_pkts[1]; base2 = rx_words[1];
    for (int k = 0; k < 2; k++) begin
      send_pkt(2, XI, 3, 0, 7 + k);
      send_pkt(3, XI, 3, 0, 9 + k);
    end
    drain();
    chk("R5 header-only packets delivered", rx_pkts[1], base + 4);
    chk("R5 header-only word count", rx_words[1], base2 + 4);

    // R6: three inputs compete for the local port
    hlog[0].delete();
    for (int k = 0; k < 2; k++)
      for (int s = 1; s <= 3; s++) send_pkt(s, XI, YI, 1, 20 + k * 4 + s);
    drain();
    chk("R6 grant count", hlog[0].size(), 6);
    if (hlog[0].size() == 6)
      for (int k = 0; k < 6; k++) chk("R6 round-robin grant order", hlog[0][k], (k % 3) + 1);

    // R7: stalled neighbour receives exactly the credit limit
    stall_force[3] = 1'b1;
    base = rx_words[3];
    send_pkt(4, 5, YI, 9, 30);
    repeat (30) @(posedge clk);
    chk("R7 stalled output holds at credit limit", rx_words[3] - base, DEP);
    stall_force[3] = 1'b0;
    drain();
    chk("R7 stalled packet completes after credits return", rx_words[3] - base, 10);

    // R4, R10: random traffic under random back-pressure
    rnd = 1;
    for (int n = 0; n < 250; n++) begin
      send_pkt(int'($urandom % NP), int'($urandom % 5), int'($urandom % 5),
               int'($urandom % 7), 100 + n);
      if (n % 5 == 0) repeat (8) @(posedge clk);
    end
    repeat (200) @(posedge clk);
    rnd = 0;
    drain();

    for (int p = 0; p < NP; p++) begin
      chk("R8 all input credits returned", tx_cred[p], DEP);
      for (int s = 0; s < NP; s++)
        chk("R4 every expected word delivered", expq[p][s].size(), 0);
    end
    finish_run();
  end
endmodule